// File: doc/BRIEF.md
# Image Sensor SPI Configuration Sequencer

This block sits on the host side of a camera link. It takes an image sensor from reset to streaming and back again by replaying fixed register-write scripts over an SPI master port. The host gives single-cycle commands: configure, power-up, enable streaming, disable streaming and power-down. The sequencer turns each accepted command into its script of 26-bit write frames and sends them one at a time.

Three static mode inputs choose some of the written values: the readout mode (normal or zero readout overhead), the array shape (square or 4:3) and the pixel depth (8 or 10 bit). The block samples these inputs when it accepts a command.

The block keeps a private copy of the streaming control register. Disabling the stream therefore clears only the enable bit and keeps the mode bits, with no readback from the sensor. Commands must arrive in lifecycle order. A command out of order gives a one-cycle error pulse and has no other effect.

Top module: `sensor_cfg_seq`

## Requirements
- R1: After reset, busy, done and err are 0, spi_csn is 1 and spi_sck is 0.
- R2: Each write frame is 26 bits, sent MSB first: a 9-bit address, then a write flag of 1, then 16 data bits. The sensor samples a bit on each rising spi_sck edge. spi_csn stays low for exactly those 26 bits, and frames never overlap.
- R3: Configure sends 14 frames in this order: 65←0x008B, 66←0x53C8, 67←0x8848, 68←0x0086, 128←0x4520, 204, 224←0x3E04, 225←0x6733, 129, 447←0x0BF1, 448←0x0BC3, 256←0x4708, 257, 258. Register 204 gets 0x09E5 in normal readout mode and 0x09E6 in zero-overhead mode.
- R4: Registers 257 and 258 get 0x0200 and 0x11FF for the square array, and 0x0400 and 0x0FFF for the 4:3 array.
- R5: Register 129 gets 0x2000 in 8-bit mode and 0x0000 in 10-bit mode. Bit 13 set means 8-bit.
- R6: Power-up sends 32←0x2003, 64←0x0001, 40←0x0003, 48←0x0001, 112←0x0007, in that order.
- R7: Enable sends one frame to register 192: 0x0001 in normal mode or 0x000D in zero-overhead mode.
- R8: Disable sends one frame to register 192. Its data is the last value written to 192 with bit 0 cleared.
- R9: Power-down sends the power-up addresses in reverse order: 112, 48, 40 and 64 get 0x0000, then 32 gets 0x2002.
- R10: Commands are accepted only in this order: configure, then power-up, then enable. After enable comes disable. After disable comes enable or power-down. After power-down comes power-up. Any other command sets err high for exactly the next cycle, sends no frame and leaves the lifecycle state unchanged.
- R11: Busy rises one cycle after a command is accepted and falls when done pulses. Done is a one-cycle pulse, one cycle after spi_csn rises at the end of the script's last frame. Commands that arrive while busy are ignored, with no err and no frames.
- R12: The mode inputs are sampled when a command is accepted. Changing them during a script does not change that script's data.
- R13: Two or more commands high in the same cycle count as an out-of-order command (R10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_cfg | input | 1 | Configure command pulse |
| cmd_pwr_up | input | 1 | Power-up command pulse |
| cmd_enable | input | 1 | Enable-streaming command pulse |
| cmd_disable | input | 1 | Disable-streaming command pulse |
| cmd_pwr_dn | input | 1 | Power-down command pulse |
| mode_zero_rot | input | 1 | 1 = zero readout-overhead mode |
| mode_4by3 | input | 1 | 1 = 4:3 array, 0 = square array |
| mode_8bit | input | 1 | 1 = 8-bit pixels, 0 = 10-bit pixels |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse at script end |
| err | output | 1 | One-cycle pulse for a rejected command |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI serial data out |

## Verification
Err and busy appear one clock after the command cycle, so the bench drives a command at a falling clock edge and reads these flags just after the next falling edge. A frame takes about 52·SCK_HALF clocks. The bench does not count cycles per frame. It rebuilds each frame from the rising spi_sck edges and compares it when spi_csn rises. Done must come one clock after the last spi_csn rise, and the bench checks this against the cycle count it recorded at that rise.

// File: rtl/sensor_cfg_pkg.sv
package sensor_cfg_pkg;

    localparam int SPI_ADDR_W = 9;
    localparam int SPI_DATA_W = 16;
    localparam int FRAME_W    = SPI_ADDR_W + 1 + SPI_DATA_W;
    localparam int IDX_W      = 4;
    localparam int CMD_W      = 5;

    localparam int CMD_CFG = 0;
    localparam int CMD_UP  = 1;
    localparam int CMD_EN  = 2;
    localparam int CMD_DIS = 3;
    localparam int CMD_DN  = 4;

    typedef enum logic [2:0] {
        PH_CFG,
        PH_UP,
        PH_EN,
        PH_DIS,
        PH_DN
    } phase_t;

    typedef enum logic [2:0] {
        L_RESET,
        L_CFGD,
        L_PWR,
        L_STREAM,
        L_STOP
    } life_t;

endpackage

// File: rtl/cfg_cmd_check.sv
module cfg_cmd_check
    import sensor_cfg_pkg::*;
(
    input  life_t                 life,
    input  logic [CMD_W-1:0]      cmd,
    output logic                  any_cmd,
    output logic                  legal,
    output phase_t                phase,
    output life_t                 life_nxt
);
    always_comb begin
        any_cmd  = |cmd;
        legal    = 1'b0;
        phase    = PH_CFG;
        life_nxt = life;
        if ($countones(cmd) == 1) begin
            case (life)
                L_RESET: if (cmd[CMD_CFG]) begin
                    legal = 1'b1; phase = PH_CFG; life_nxt = L_CFGD;
                end
                L_CFGD: if (cmd[CMD_UP]) begin
                    legal = 1'b1; phase = PH_UP; life_nxt = L_PWR;
                end
                L_PWR: if (cmd[CMD_EN]) begin
                    legal = 1'b1; phase = PH_EN; life_nxt = L_STREAM;
                end
                L_STREAM: if (cmd[CMD_DIS]) begin
                    legal = 1'b1; phase = PH_DIS; life_nxt = L_STOP;
                end
                L_STOP: begin
                    if (cmd[CMD_EN]) begin
                        legal = 1'b1; phase = PH_EN; life_nxt = L_STREAM;
                    end else if (cmd[CMD_DN]) begin
                        legal = 1'b1; phase = PH_DN; life_nxt = L_CFGD;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_script_rom.sv
module cfg_script_rom
    import sensor_cfg_pkg::*;
(
    input  phase_t                 phase,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   zero_rot,
    input  logic                   res_4by3,
    input  logic                   depth_8,
    input  logic [SPI_DATA_W-1:0]  shadow,
    output logic [SPI_ADDR_W-1:0]  addr,
    output logic [SPI_DATA_W-1:0]  data,
    output logic                   last
);
    localparam int CFG_LEN = 14;
    localparam int UP_LEN  = 5;
    localparam logic [SPI_ADDR_W-1:0] CTRL_ADDR = SPI_ADDR_W'(192);

    function automatic logic [SPI_ADDR_W-1:0] up_addr(input logic [2:0] i);
        case (i)
            3'd0:    up_addr = SPI_ADDR_W'(32);
            3'd1:    up_addr = SPI_ADDR_W'(64);
            3'd2:    up_addr = SPI_ADDR_W'(40);
            3'd3:    up_addr = SPI_ADDR_W'(48);
            default: up_addr = SPI_ADDR_W'(112);
        endcase
    endfunction

    function automatic logic [SPI_DATA_W-1:0] up_data(input logic [2:0] i);
        case (i)
            3'd0:    up_data = 16'h2003;
            3'd1:    up_data = 16'h0001;
            3'd2:    up_data = 16'h0003;
            3'd3:    up_data = 16'h0001;
            default: up_data = 16'h0007;
        endcase
    endfunction

    logic [2:0] rev_idx;
    assign rev_idx = 3'(UP_LEN - 1) - idx[2:0];

    always_comb begin
        addr = '0;
        data = '0;
        last = 1'b1;
        case (phase)
            PH_CFG: begin
                last = (idx == IDX_W'(CFG_LEN - 1));
                case (idx)
                    4'd0:  begin addr = SPI_ADDR_W'(65);  data = 16'h008B; end
                    4'd1:  begin addr = SPI_ADDR_W'(66);  data = 16'h53C8; end
                    4'd2:  begin addr = SPI_ADDR_W'(67);  data = 16'h8848; end
                    4'd3:  begin addr = SPI_ADDR_W'(68);  data = 16'h0086; end
                    4'd4:  begin addr = SPI_ADDR_W'(128); data = 16'h4520; end
                    4'd5:  begin addr = SPI_ADDR_W'(204);
                                 data = zero_rot ? 16'h09E6 : 16'h09E5; end
                    4'd6:  begin addr = SPI_ADDR_W'(224); data = 16'h3E04; end
                    4'd7:  begin addr = SPI_ADDR_W'(225); data = 16'h6733; end
                    4'd8:  begin addr = SPI_ADDR_W'(129);
                                 data = depth_8 ? 16'h2000 : 16'h0000; end
                    4'd9:  begin addr = SPI_ADDR_W'(447); data = 16'h0BF1; end
                    4'd10: begin addr = SPI_ADDR_W'(448); data = 16'h0BC3; end
                    4'd11: begin addr = SPI_ADDR_W'(256); data = 16'h4708; end
                    4'd12: begin addr = SPI_ADDR_W'(257);
                                 data = res_4by3 ? 16'h0400 : 16'h0200; end
                    4'd13: begin addr = SPI_ADDR_W'(258);
                                 data = res_4by3 ? 16'h0FFF : 16'h11FF; end
                    default: last = 1'b1;
                endcase
            end
            PH_UP: begin
                addr = up_addr(idx[2:0]);
                data = up_data(idx[2:0]);
                last = (idx >= IDX_W'(UP_LEN - 1));
            end
            PH_DN: begin
                addr = up_addr(rev_idx);
                data = (idx == IDX_W'(UP_LEN - 1)) ? 16'h2002 : 16'h0000;
                last = (idx >= IDX_W'(UP_LEN - 1));
            end
            PH_EN: begin
                addr = CTRL_ADDR;
                data = zero_rot ? 16'h000D : 16'h0001;
            end
            PH_DIS: begin
                addr = CTRL_ADDR;
                data = shadow & ~SPI_DATA_W'(1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_frame_tx.sv
module spi_frame_tx
    import sensor_cfg_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               fin,
    output logic               spi_csn,
    output logic               spi_sck,
    output logic               spi_mosi
);
    localparam int HC_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int BC_W = $clog2(FRAME_W + 1);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(SCK_HALF - 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_W - 1);

    typedef enum logic [1:0] {SX_IDLE, SX_LOW, SX_HIGH} sx_t;

    typedef struct packed {
        sx_t                st;
        logic [FRAME_W-1:0] sh;
        logic [HC_W-1:0]    cnt;
        logic [BC_W-1:0]    bits;
        logic               csn;
        logic               sck;
        logic               fin;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d     = tx_q;
        tx_d.fin = 1'b0;
        case (tx_q.st)
            SX_IDLE: if (start) begin
                tx_d.sh   = frame;
                tx_d.csn  = 1'b0;
                tx_d.cnt  = '0;
                tx_d.bits = '0;
                tx_d.st   = SX_LOW;
            end
            SX_LOW: begin
                if (tx_q.cnt == HC_LAST) begin
                    tx_d.cnt = '0;
                    tx_d.sck = 1'b1;
                    tx_d.st  = SX_HIGH;
                end else begin
                    tx_d.cnt = tx_q.cnt + 1'b1;
                end
            end
            SX_HIGH: begin
                if (tx_q.cnt == HC_LAST) begin
                    tx_d.cnt = '0;
                    tx_d.sck = 1'b0;
                    if (tx_q.bits == BC_LAST) begin
                        tx_d.csn = 1'b1;
                        tx_d.fin = 1'b1;
                        tx_d.st  = SX_IDLE;
                    end else begin
                        tx_d.bits = tx_q.bits + 1'b1;
                        tx_d.sh   = {tx_q.sh[FRAME_W-2:0], 1'b0};
                        tx_d.st   = SX_LOW;
                    end
                end else begin
                    tx_d.cnt = tx_q.cnt + 1'b1;
                end
            end
            default: tx_d.st = SX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            tx_q.st  <= SX_IDLE;
            tx_q.csn <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign fin      = tx_q.fin;
    assign spi_csn  = tx_q.csn;
    assign spi_sck  = tx_q.sck;
    assign spi_mosi = tx_q.sh[FRAME_W-1];
endmodule

// File: rtl/sensor_cfg_seq.sv
module sensor_cfg_seq
    import sensor_cfg_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_cfg,
    input  logic cmd_pwr_up,
    input  logic cmd_enable,
    input  logic cmd_disable,
    input  logic cmd_pwr_dn,
    input  logic mode_zero_rot,
    input  logic mode_4by3,
    input  logic mode_8bit,
    output logic busy,
    output logic done,
    output logic err,
    output logic spi_csn,
    output logic spi_sck,
    output logic spi_mosi
);
    typedef struct packed {
        life_t                 life;
        logic                  busy;
        phase_t                phase;
        logic [IDX_W-1:0]      idx;
        logic                  zrot;
        logic                  r43;
        logic                  d8;
        logic [SPI_DATA_W-1:0] shadow;
        logic                  start;
        logic                  done;
        logic                  err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CMD_W-1:0]      cmd_vec;
    logic                  any_cmd, legal;
    phase_t                cmd_phase;
    life_t                 life_nxt;
    logic [SPI_ADDR_W-1:0] rom_addr;
    logic [SPI_DATA_W-1:0] rom_data;
    logic                  rom_last;
    logic                  tx_fin;

    assign cmd_vec[CMD_CFG] = cmd_cfg;
    assign cmd_vec[CMD_UP]  = cmd_pwr_up;
    assign cmd_vec[CMD_EN]  = cmd_enable;
    assign cmd_vec[CMD_DIS] = cmd_disable;
    assign cmd_vec[CMD_DN]  = cmd_pwr_dn;

    cfg_cmd_check u_check (
        .life     (ctl_q.life),
        .cmd      (cmd_vec),
        .any_cmd  (any_cmd),
        .legal    (legal),
        .phase    (cmd_phase),
        .life_nxt (life_nxt)
    );

    cfg_script_rom u_rom (
        .phase    (ctl_q.phase),
        .idx      (ctl_q.idx),
        .zero_rot (ctl_q.zrot),
        .res_4by3 (ctl_q.r43),
        .depth_8  (ctl_q.d8),
        .shadow   (ctl_q.shadow),
        .addr     (rom_addr),
        .data     (rom_data),
        .last     (rom_last)
    );

    spi_frame_tx #(.SCK_HALF(SCK_HALF)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ctl_q.start),
        .frame    ({rom_addr, 1'b1, rom_data}),
        .fin      (tx_fin),
        .spi_csn  (spi_csn),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.done  = 1'b0;
        ctl_d.err   = 1'b0;
        if (!ctl_q.busy) begin
            if (any_cmd) begin
                if (legal) begin
                    ctl_d.busy  = 1'b1;
                    ctl_d.phase = cmd_phase;
                    ctl_d.idx   = '0;
                    ctl_d.zrot  = mode_zero_rot;
                    ctl_d.r43   = mode_4by3;
                    ctl_d.d8    = mode_8bit;
                    ctl_d.life  = life_nxt;
                    ctl_d.start = 1'b1;
                end else begin
                    ctl_d.err = 1'b1;
                end
            end
        end else if (tx_fin) begin
            if (rom_last) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
                if (ctl_q.phase == PH_EN || ctl_q.phase == PH_DIS) begin
                    ctl_d.shadow = rom_data;
                end
            end else begin
                ctl_d.idx   = ctl_q.idx + 1'b1;
                ctl_d.start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.life  <= L_RESET;
            ctl_q.phase <= PH_CFG;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = ctl_q.busy;
    assign done = ctl_q.done;
    assign err  = ctl_q.err;
endmodule

// File: rtl/sensor_cfg_seq_chk.sv
module sensor_cfg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic spi_csn,
    input logic spi_sck,
    input logic spi_mosi
);
    // R2
    csn_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_csn |-> busy);

    // R2
    sck_idle_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_sck);

    // R2
    mosi_steady_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi));

    // R10
    err_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !$past(busy)));

    // R11
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R11
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R11
    done_after_csn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(spi_csn) == 1'b0 && spi_csn && $past(spi_csn) && !$past(spi_csn, 2));
endmodule

bind sensor_cfg_seq sensor_cfg_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .spi_csn  (spi_csn),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/sim_sensor_cfg_seq.sv
module sim_sensor_cfg_seq;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic cmd_cfg, cmd_pwr_up, cmd_enable, cmd_disable, cmd_pwr_dn;
    logic mode_zero_rot, mode_4by3, mode_8bit;
    logic busy, done, err, spi_csn, spi_sck, spi_mosi;

    sensor_cfg_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_cfg(cmd_cfg), .cmd_pwr_up(cmd_pwr_up), .cmd_enable(cmd_enable),
        .cmd_disable(cmd_disable), .cmd_pwr_dn(cmd_pwr_dn),
        .mode_zero_rot(mode_zero_rot), .mode_4by3(mode_4by3), .mode_8bit(mode_8bit),
        .busy(busy), .done(done), .err(err),
        .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    localparam logic [4:0] C_CFG = 5'b00001;
    localparam logic [4:0] C_UP  = 5'b00010;
    localparam logic [4:0] C_EN  = 5'b00100;
    localparam logic [4:0] C_DIS = 5'b01000;
    localparam logic [4:0] C_DN  = 5'b10000;

    int checks = 0;
    int errors = 0;
    bit summary_done = 1'b0;

    logic [25:0] exp_q[$];
    string       tag_q[$];

    int cyc = 0;
    int last_rise = -10;
    int frames = 0;
    int nbits = 0;
    logic [25:0] shreg = '0;
    logic prev_csn = 1'b1;
    logic prev_sck = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: rebuilds frames from rising spi_sck, compares at spi_csn rise
    always @(negedge clk) begin
        cyc++;
        if (!spi_csn && prev_csn) begin
            nbits = 0;
            shreg = '0;
        end
        if (!spi_csn && spi_sck && !prev_sck) begin
            shreg = {shreg[24:0], spi_mosi};
            nbits++;
        end
        if (spi_csn && !prev_csn) begin
            last_rise = cyc;
            frames++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected frame", 32'(shreg), 32'h0);
            end else begin
                logic [25:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(nbits == 26, "R2 bit count", 32'(nbits), 32'd26);
                chk(shreg == e, t, 32'(shreg), 32'(e));
            end
        end
        prev_csn = spi_csn;
        prev_sck = spi_sck;
    end

    task automatic push(input int addr, input logic [15:0] data, input string tag);
        exp_q.push_back({9'(addr), 1'b1, data});
        tag_q.push_back(tag);
    endtask

    task automatic push_cfg(input bit zr, input bit r43, input bit d8);
        push(65,  16'h008B, "R3 cfg 65");
        push(66,  16'h53C8, "R3 cfg 66");
        push(67,  16'h8848, "R3 cfg 67");
        push(68,  16'h0086, "R3 cfg 68");
        push(128, 16'h4520, "R3 cfg 128");
        push(204, zr ? 16'h09E6 : 16'h09E5, "R3 cfg 204");
        push(224, 16'h3E04, "R3 cfg 224");
        push(225, 16'h6733, "R3 cfg 225");
        push(129, d8 ? 16'h2000 : 16'h0000, "R5 cfg 129 depth");
        push(447, 16'h0BF1, "R3 cfg 447");
        push(448, 16'h0BC3, "R3 cfg 448");
        push(256, 16'h4708, "R3 cfg 256");
        push(257, r43 ? 16'h0400 : 16'h0200, "R4 cfg 257");
        push(258, r43 ? 16'h0FFF : 16'h11FF, "R4 cfg 258");
    endtask

    task automatic push_up();
        push(32,  16'h2003, "R6 up 32");
        push(64,  16'h0001, "R6 up 64");
        push(40,  16'h0003, "R6 up 40");
        push(48,  16'h0001, "R6 up 48");
        push(112, 16'h0007, "R6 up 112");
    endtask

    task automatic push_dn();
        push(112, 16'h0000, "R9 dn 112");
        push(48,  16'h0000, "R9 dn 48");
        push(40,  16'h0000, "R9 dn 40");
        push(64,  16'h0000, "R9 dn 64");
        push(32,  16'h2002, "R9 dn 32");
    endtask

    task automatic set_cmd(input logic [4:0] c);
        cmd_cfg     = c[0];
        cmd_pwr_up  = c[1];
        cmd_enable  = c[2];
        cmd_disable = c[3];
        cmd_pwr_dn  = c[4];
    endtask

    // Drives one command cycle; returns just after the next falling edge
    task automatic issue(input logic [4:0] c);
        @(negedge clk);
        set_cmd(c);
        @(negedge clk);
        set_cmd(5'b0);
        #1;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (done !== 1'b1 && n < 20000) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(done === 1'b1, {tag, " R11 done seen"}, 32'(done), 32'h1);
        chk(cyc == last_rise + 1, {tag, " R11 done one cycle after csn rise"},
            32'(cyc - last_rise), 32'h1);
        chk(busy === 1'b0, {tag, " R11 busy low with done"}, 32'(busy), 32'h0);
        chk(exp_q.size() == 0, {tag, " all frames sent"}, 32'(exp_q.size()), 32'h0);
        @(negedge clk);
        #1;
        chk(done === 1'b0, {tag, " R11 done one cycle"}, 32'(done), 32'h0);
    endtask

    task automatic run(input logic [4:0] c, input string tag);
        issue(c);
        chk(busy === 1'b1, {tag, " R11 busy after accept"}, 32'(busy), 32'h1);
        chk(err === 1'b0, {tag, " R10 no err on legal"}, 32'(err), 32'h0);
        wait_done(tag);
    endtask

    task automatic expect_err(input logic [4:0] c, input string tag);
        int f0;
        f0 = frames;
        issue(c);
        chk(err === 1'b1, {tag, " err pulse"}, 32'(err), 32'h1);
        chk(busy === 1'b0, {tag, " no busy"}, 32'(busy), 32'h0);
        @(negedge clk);
        #1;
        chk(err === 1'b0, {tag, " err one cycle"}, 32'(err), 32'h0);
        repeat (300) @(negedge clk);
        #1;
        chk(frames == f0, {tag, " no frames"}, 32'(frames - f0), 32'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 flags after reset",
            {29'b0, busy, done, err}, 32'h0);
        chk(spi_csn === 1'b1 && spi_sck === 1'b0, "R1 spi idle after reset",
            {30'b0, spi_csn, spi_sck}, 32'h2);
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        set_cmd(5'b0);
        mode_zero_rot = 1'b0;
        mode_4by3     = 1'b0;
        mode_8bit     = 1'b0;
        do_reset();

        // R10: enable before configure; R13: two commands together
        expect_err(C_EN, "R10 enable from reset");
        expect_err(C_CFG | C_UP, "R13 two commands");

        // R12 and R11: configure, modes change and stray command mid-script
        push_cfg(1'b0, 1'b0, 1'b0);
        issue(C_CFG);
        chk(busy === 1'b1, "R11 busy after configure", 32'(busy), 32'h1);
        repeat (200) @(negedge clk);
        mode_zero_rot = 1'b1;
        mode_4by3     = 1'b1;
        mode_8bit     = 1'b1;
        issue(C_UP);
        chk(err === 1'b0, "R11 command while busy no err", 32'(err), 32'h0);
        wait_done("R12 configure latched modes");

        mode_zero_rot = 1'b0;
        push_up();
        run(C_UP, "R6 power-up");

        push(192, 16'h0001, "R7 enable normal");
        run(C_EN, "R7 enable");
        push(192, 16'h0000, "R8 disable normal");
        run(C_DIS, "R8 disable");

        expect_err(C_UP, "R10 power-up while stopped");

        mode_zero_rot = 1'b1;
        push(192, 16'h000D, "R7 enable zero overhead");
        run(C_EN, "R7 enable zr");
        mode_zero_rot = 1'b0;
        expect_err(C_EN, "R10 enable while streaming");
        push(192, 16'h000C, "R8 disable keeps mode bits");
        run(C_DIS, "R8 disable zr");

        push_dn();
        run(C_DN, "R9 power-down");

        expect_err(C_CFG, "R10 configure after power-down");
        push_up();
        run(C_UP, "R10 power-up after power-down");

        // Second reset, other mode set
        do_reset();
        mode_zero_rot = 1'b1;
        mode_4by3     = 1'b1;
        mode_8bit     = 1'b1;
        push_cfg(1'b1, 1'b1, 1'b1);
        run(C_CFG, "R3 R4 R5 configure alt modes");

        repeat (10) @(negedge clk);
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end
endmodule